// File: doc/BRIEF.md
# Dual-Rule Cellular Automaton Row Iterator

This block streams one row of a grid in which every cell holds a 2-bit state. It accepts one column slice per clock cycle. A slice carries three cells: the row being updated, the row above it and the row below it. The block produces the next state of that row's cell for each column. Internally it keeps a window three columns wide, so the update rule sees the full 3x3 neighbourhood of the cell it is working on.

A single runtime input picks which automaton the rule applies. One setting selects the Wireworld wire-signal rule. The other selects Conway's Game of Life. Positions beyond either end of a row are treated as Empty, so the grid never wraps and one row never bleeds into the next.

The block reads two columns ahead of the column it emits. A caller that writes each result back to the storage it reads from will therefore never overwrite a value that is still needed. Address generation, storage and display are the caller's job.

Top module: `ca_row_iter`

## Requirements
- R1: Wireworld mode (`life_mode`=0) uses the codes 00 Empty, 01 Head, 10 Tail and 11 Conductor. A Head becomes a Tail, a Tail becomes a Conductor, and an Empty stays Empty.
- R2: In Wireworld mode, a Conductor becomes a Head when one or two of its eight neighbours are Heads. With any other number of Head neighbours it stays a Conductor.
- R3: In Life mode (`life_mode`=1), any nonzero code counts as alive. A live cell with two or three live neighbours stays alive, and a dead cell with exactly three live neighbours becomes alive. A live result is output as 01 and a dead result as 00.
- R4: `life_mode` may change between streams at run time. It must be held steady from a column's beat through the following cycle, and that column's result follows the rule it selects.
- R5: A column flagged `in_first` sees Empty to its left, and a column flagged `in_last` sees Empty to its right. This holds for back-to-back rows and for single-column rows.
- R6: The result for a beat appears on `out_state`, with `out_valid` high, exactly two cycles after that beat. Beats within one row must arrive on consecutive cycles.
- R7: During reset and after reset release, `out_valid` and `out_state` are zero until two cycles after the first beat.
- R8: In a cycle whose beat two cycles earlier was idle, `out_valid` is low and `out_state` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| life_mode | input | 1 | Rule select: 0 Wireworld, 1 Game of Life |
| in_valid | input | 1 | A column slice is present this cycle |
| in_first | input | 1 | This slice is the first column of a row |
| in_last | input | 1 | This slice is the last column of a row |
| in_slice | input | 6 | Column slice: bits [1:0] row above, [3:2] own row, [5:4] row below |
| out_valid | output | 1 | `out_state` holds the result of the beat two cycles earlier |
| out_state | output | 2 | Next state of the own-row cell |

## Verification
The bench sweeps every possible count of Head neighbours around a Conductor. A design that used the wrong threshold would fire the Conductor at zero or three Heads, or miss it at two. It also walks all 512 alive/dead patterns of a 3x3 Life neighbourhood, using mixed nonzero codes as "alive". A design that counted only code 01 as alive, or that included the centre cell in its count, would give wrong results. Back-to-back rows, including a single-column row, check that no cell from a neighbouring row leaks in at the row boundaries. Idle gaps and the reset period check that `out_valid` follows the two-cycle latency exactly and never stays high stale.

// File: rtl/ca_pkg.sv
// Shared cell encoding and slice geometry for the row iterator.
package ca_pkg;
    localparam int CELL_W     = 2;
    localparam int SLICE_ROWS = 3;
    localparam int SLICE_W    = CELL_W * SLICE_ROWS;
    localparam int WIN_COLS   = 3;
    localparam int WIN_W      = SLICE_W * WIN_COLS;

    typedef enum logic [CELL_W-1:0] {
        CELL_EMPTY = 2'b00,
        CELL_HEAD  = 2'b01,
        CELL_TAIL  = 2'b10,
        CELL_COND  = 2'b11
    } cell_t;
endpackage

// File: rtl/ca_window.sv
// Three-column sliding window.
// Holds the column under update (centre) and the column before it (west).
// East is taken straight from the incoming beat.
// Assumes beats inside a row arrive on consecutive cycles.
// Row edges are replaced by all-Empty slices.
module ca_window
    import ca_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [SLICE_W-1:0] in_slice,
    output logic               win_valid,
    output logic [SLICE_W-1:0] win_west,
    output logic [SLICE_W-1:0] win_centre,
    output logic [SLICE_W-1:0] win_east
);
    logic ctr_last;

    // Shift a new beat into the window; on a row start the west column is Empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid  <= 1'b0;
            win_west   <= '0;
            win_centre <= '0;
            ctr_last   <= 1'b0;
        end else begin
            win_valid <= in_valid;
            if (in_valid) begin
                win_centre <= in_slice;
                win_west   <= in_first ? '0 : win_centre;
                ctr_last   <= in_last;
            end
        end
    end

    // East neighbour: the live beat, unless the row ended or a new one starts.
    always_comb begin
        win_east = '0;
        if (in_valid && !in_first && !ctr_last)
            win_east = in_slice;
    end
endmodule

// File: rtl/ca_rule_core.sv
// Combinational next-state rule for one cell.
// It sees a 3x3 neighbourhood packed column-major, with cell index col*3+row
// and the centre at index 4, and applies Wireworld or Game of Life.
// Assumes the cell codes of ca_pkg.
module ca_rule_core
    import ca_pkg::*;
#(
    parameter int HEAD_MIN = 1,
    parameter int HEAD_MAX = 2,
    parameter int BIRTH    = 3,
    parameter int SURV_MIN = 2,
    parameter int SURV_MAX = 3
) (
    input  logic              life_mode,
    input  logic [WIN_W-1:0]  nbhd,
    output logic [CELL_W-1:0] next_cell
);
    localparam int CELLS  = SLICE_ROWS * WIN_COLS;
    localparam int CENTRE = CELLS / 2;

    logic [CELLS-1:0] head_v;
    logic [CELLS-1:0] live_v;
    logic [CELL_W-1:0] self_cell;
    int n_head;
    int n_live;

    assign self_cell = nbhd[CENTRE*CELL_W +: CELL_W];

    // Per-neighbour flags; the centre cell never counts.
    generate
        for (genvar g = 0; g < CELLS; g++) begin : g_cell
            if (g == CENTRE) begin : g_self
                assign head_v[g] = 1'b0;
                assign live_v[g] = 1'b0;
            end else begin : g_nb
                assign head_v[g] = (nbhd[g*CELL_W +: CELL_W] == CELL_HEAD);
                assign live_v[g] = |nbhd[g*CELL_W +: CELL_W];
            end
        end
    endgenerate

    // Population counts of Head and live neighbours.
    always_comb begin
        n_head = 0;
        n_live = 0;
        for (int i = 0; i < CELLS; i++) begin
            n_head = n_head + 32'(head_v[i]);
            n_live = n_live + 32'(live_v[i]);
        end
    end

    // Rule selection and next-state decode.
    always_comb begin
        next_cell = CELL_EMPTY;
        if (life_mode) begin
            if (|self_cell)
                next_cell = (n_live >= SURV_MIN && n_live <= SURV_MAX) ? CELL_HEAD : CELL_EMPTY;
            else
                next_cell = (n_live == BIRTH) ? CELL_HEAD : CELL_EMPTY;
        end else begin
            case (self_cell)
                CELL_HEAD: next_cell = CELL_TAIL;
                CELL_TAIL: next_cell = CELL_COND;
                CELL_COND: next_cell = (n_head >= HEAD_MIN && n_head <= HEAD_MAX) ? CELL_HEAD : CELL_COND;
                default:   next_cell = CELL_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/ca_row_iter.sv
// Top: row iterator for a 2-bit cellular automaton.
// Window stage, rule core and a registered output.
// The result for a beat leaves two cycles after it, while the caller is
// already presenting the column two places ahead.
module ca_row_iter
    import ca_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               life_mode,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [SLICE_W-1:0] in_slice,
    output logic               out_valid,
    output logic [CELL_W-1:0]  out_state
);
    logic               win_valid;
    logic [SLICE_W-1:0] win_west;
    logic [SLICE_W-1:0] win_centre;
    logic [SLICE_W-1:0] win_east;
    logic [CELL_W-1:0]  next_cell;

    ca_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_last    (in_last),
        .in_slice   (in_slice),
        .win_valid  (win_valid),
        .win_west   (win_west),
        .win_centre (win_centre),
        .win_east   (win_east)
    );

    ca_rule_core u_rule (
        .life_mode (life_mode),
        .nbhd      ({win_east, win_centre, win_west}),
        .next_cell (next_cell)
    );

    // Register the result; idle cycles drive zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_state <= '0;
        end else begin
            out_valid <= win_valid;
            out_state <= win_valid ? next_cell : '0;
        end
    end
endmodule

// File: rtl/ca_row_iter_chk.sv
// Checker for ca_row_iter: latency, idle behaviour and fixed Wireworld and
// Life transitions.
// It watches the centre cell held in the window.
module ca_row_iter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       life_mode,
    input logic       in_valid,
    input logic       win_valid,
    input logic [1:0] ctr_cell,
    input logic       out_valid,
    input logic [1:0] out_state
);
    logic [1:0] age;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (!out_valid && out_state == 2'b00));
    assert_head_to_tail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !life_mode && ctr_cell == 2'b01) |=> (out_valid && out_state == 2'b10));
    assert_tail_to_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !life_mode && ctr_cell == 2'b10) |=> (out_state == 2'b11));
    assert_empty_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !life_mode && ctr_cell == 2'b00) |=> (out_state == 2'b00));
    assert_life_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && life_mode) |=> (out_state[1] == 1'b0));
endmodule

bind ca_row_iter ca_row_iter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .life_mode (life_mode),
    .in_valid  (in_valid),
    .win_valid (win_valid),
    .ctr_cell  (win_centre[3:2]),
    .out_valid (out_valid),
    .out_state (out_state)
);

// File: tb/ca_row_iter_test.sv
// Bench for ca_row_iter: near-exhaustive neighbourhood sweeps with a
// reference next-state computed from the requirements.
module ca_row_iter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       life_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic [5:0] in_slice = '0;
    logic       out_valid;
    logic [1:0] out_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [5:0] bs [64];
    bit         bf [64];
    bit         bl [64];
    int         nb;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    ca_row_iter uut (
        .clk(clk), .rst_n(rst_n), .life_mode(life_mode), .in_valid(in_valid),
        .in_first(in_first), .in_last(in_last), .in_slice(in_slice),
        .out_valid(out_valid), .out_state(out_state)
    );

    task automatic chk(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] rnd2();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[1:0];
    endfunction

    // Reference next state; w is column-major, index col*3+row, centre 4.
    function automatic logic [1:0] ref_cell(bit md, logic [17:0] w);
        int heads = 0;
        int live = 0;
        logic [1:0] c = w[9:8];
        for (int i = 0; i < 9; i++) begin
            if (i != 4) begin
                if (w[i*2 +: 2] == 2'b01) heads++;
                if (w[i*2 +: 2] != 2'b00) live++;
            end
        end
        if (md)
            return ((c != 0 && (live == 2 || live == 3)) || (c == 0 && live == 3)) ? 2'b01 : 2'b00;
        case (c)
            2'b00:   return 2'b00;
            2'b01:   return 2'b10;
            2'b10:   return 2'b11;
            default: return (heads == 1 || heads == 2) ? 2'b01 : 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] expect_beat(bit md, int k);
        logic [5:0] west = (k > 0 && !bf[k]) ? bs[k-1] : 6'd0;
        logic [5:0] east = (k < nb - 1 && !bl[k]) ? bs[k+1] : 6'd0;
        return ref_cell(md, {east, bs[k], west});
    endfunction

    // Stream nb beats back to back, sampling each result two cycles later.
    task automatic run_stream(bit md, string tag);
        life_mode = md;
        for (int i = 0; i < nb + 3; i++) begin
            @(negedge clk);
            if (i >= 2 && i - 2 < nb) begin
                logic [1:0] e = expect_beat(md, i - 2);
                chk(out_valid === 1'b1, "R6", {2'b0, out_valid}, 3'd1);
                chk(out_state === e, tag, {1'b0, out_state}, {1'b0, e});
            end else begin
                chk(out_valid === 1'b0 && out_state === 2'b00, "R8",
                    {out_valid, out_state}, 3'd0);
            end
            if (i < nb) begin
                in_valid = 1'b1; in_first = bf[i]; in_last = bl[i]; in_slice = bs[i];
            end else begin
                in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_slice = '0;
            end
        end
    endtask

    // Load a single 3-column row from a column-major 3x3 pattern.
    task automatic load3(logic [17:0] w);
        nb = 3;
        for (int c = 0; c < 3; c++) begin
            bs[c] = w[c*6 +: 6]; bf[c] = (c == 0); bl[c] = (c == 2);
        end
    endtask

    // Set up rows of the given lengths, back to back, with random cells.
    task automatic load_rows(int a, int b, int c);
        int lens [3];
        int k = 0;
        lens[0] = a; lens[1] = b; lens[2] = c;
        for (int r = 0; r < 3; r++)
            for (int j = 0; j < lens[r]; j++) begin
                bs[k] = {rnd2(), rnd2(), rnd2()};
                bf[k] = (j == 0); bl[k] = (j == lens[r] - 1);
                k++;
            end
        nb = k;
    endtask

    initial begin
        // R7: reset state and quiet after release
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && out_state === 2'b00, "R7", {out_valid, out_state}, 3'd0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0 && out_state === 2'b00, "R7", {out_valid, out_state}, 3'd0);
        end

        // R2: Conductor centre with every Head-neighbour count 0..8
        for (int h = 0; h <= 8; h++) begin
            logic [17:0] w = '0;
            int placed = 0;
            w[9:8] = 2'b11;
            for (int i = 0; i < 9; i++) begin
                if (i != 4) begin
                    w[i*2 +: 2] = (placed < h) ? 2'b01 : ((h % 2) ? 2'b11 : 2'b10);
                    placed++;
                end
            end
            load3(w);
            run_stream(1'b0, "R2");
        end

        // R1: every centre code with random surroundings in Wireworld mode
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 16; t++) begin
                logic [17:0] w;
                for (int i = 0; i < 9; i++) w[i*2 +: 2] = rnd2();
                w[9:8] = 2'(s);
                load3(w);
                run_stream(1'b0, "R1");
            end

        // R3: all 512 alive/dead patterns, alive drawn from mixed nonzero codes
        for (int p = 0; p < 512; p++) begin
            logic [17:0] w;
            for (int j = 0; j < 9; j++)
                w[j*2 +: 2] = p[j] ? 2'(((p + j) % 3) + 1) : 2'b00;
            load3(w);
            run_stream(1'b1, "R3");
        end

        // R5: back-to-back rows including a single-column row, both rules
        for (int r = 0; r < 6; r++) begin
            load_rows(7, 1, 5);
            run_stream(1'b0, "R5");
            load_rows(4, 1, 9);
            run_stream(1'b1, "R5");
        end

        // R4: long rows with the rule switched between consecutive streams
        for (int r = 0; r < 8; r++) begin
            load_rows(20, 12, 2);
            run_stream(r[0], "R4");
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule